// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital half of an 8-bit successive-approximation analog-to-digital converter with eight input channels. A single-cycle start command, qualified by a channel number, opens a conversion. The block then drives the analog multiplexer select, opens a sampling window, and feeds an external DAC one trial code per bit decision. It reads back a single comparator bit and keeps or drops each trial bit, from the most significant bit to the least significant bit. At the end it writes the 8-bit result register and raises both a one-cycle done strobe and a sticky interrupt flag. The multiplexer, DAC and comparator sit outside the block.

Every phase is counted in conversion-clock periods, and an internal prescaler derives the conversion clock from the main clock. A conversion takes 160 periods: 12 for sampling, then 18 for each of the eight bit decisions, then 4 for a final latch phase. The prescaler ratio depends on a divide-select bit and a two-bit clock-select field. The block samples both when it accepts a start, so the conversion keeps one rate from beginning to end.

Top module: `sar_conv_seq`

## Requirements
- R1: An accepted start (`startReq` high while `busy` is low) raises `busy` at the next edge and loads `chanSel` into `muxSel`. `muxSel` keeps that value until the next accepted start.
- R2: One conversion-clock period lasts N main-clock cycles. With `divSel`=0, N is 2 for `clkSel`=00, 4 for 01 and 16 for 10 or 11. With `divSel`=1, N is 1 for 00, 2 for 01 and 8 for 10 or 11. Both inputs are sampled only at the accepted start.
- R3: `busy` stays high for exactly 160·N main-clock cycles. It falls at the same edge that writes `result`.
- R4: `sampleEn` is high for exactly the first 12·N cycles of a conversion and low otherwise. `trialCode` is 0 while sampling.
- R5: After sampling, bit 7 down to bit 0 are resolved in turn, with each decision lasting 18·N cycles. During a decision, `trialCode` holds the bits already kept with the bit under test set and all lower bits clear. At the last edge of the decision the bit stays set if `cmpIn` is 1 (input at or above the trial code) and is cleared otherwise.
- R6: During the final 4·N cycles, and while idle afterwards, `trialCode` shows the completed code without a trial bit.
- R7: A start request that arrives while `busy` is high has no effect. This includes a request in the cycle where the conversion completes. `muxSel`, the timing and the result are unchanged. A request held high is accepted at the first edge where `busy` is low.
- R8: `result` changes only at the completion edge, and then takes the code built from the comparator decisions.
- R9: `donePulse` is high for exactly one cycle, the cycle that follows the completion edge.
- R10: `irqFlag` is set at the completion edge and stays set until an edge where `rdStrobe` is high. If completion and `rdStrobe` coincide, the flag is set.
- R11: While reset is asserted, and afterwards until the first start, `busy`, `sampleEn`, `donePulse` and `irqFlag` are low. `muxSel`, `trialCode` and `result` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock (fc) |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Conversion start command |
| chanSel | input | CH_W | Channel to convert, taken at start |
| divSel | input | 1 | Prescaler divide select (1 = faster) |
| clkSel | input | 2 | System clock-select code |
| rdStrobe | input | 1 | Result read; clears the interrupt flag |
| cmpIn | input | 1 | Comparator: 1 when input is at or above the trial code |
| muxSel | output | CH_W | Analog multiplexer select |
| sampleEn | output | 1 | Sample-and-hold enable |
| trialCode | output | 8 | Code sent to the external DAC |
| busy | output | 1 | Conversion in progress |
| donePulse | output | 1 | One-cycle completion strobe |
| irqFlag | output | 1 | Sticky completion interrupt flag |
| result | output | 8 | Last conversion result |

## Verification
Some of the cases are hard to reach from the ports. These include a start request in the exact completion cycle, a read strobe that coincides with the flag being set, and a rate change while a conversion is running. The stimulus therefore holds `startReq` or `rdStrobe` high across a whole conversion, so the completion edge always meets them. It also flips `divSel` and `clkSel` right after a start has been accepted. A behavioural model, indexed by cycles since start, predicts every output on every clock. The bench's comparator answers from per-channel values, so a wrong `muxSel` or a misplaced decision shows up in both the trial codes and the result.

// File: rtl/sar_pkg.sv
package sar_pkg;

  localparam int RES_W = 8;
  localparam int IDX_W = $clog2(RES_W);
  localparam int MAX_SHIFT = 4;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SAMPLE,
    ST_DECIDE,
    ST_LATCH
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic             load;
    logic             decide;
    logic             commit;
    logic             trialOn;
    logic [IDX_W-1:0] bitIdx;
  } seqStrobe_t;

  // log2 of the prescaler ratio; code 10 behaves as code 11
  function automatic logic [2:0] divShift(input logic divSel, input logic [1:0] clkSel);
    logic [2:0] base;
    case (clkSel)
      2'b00:   base = 3'd1;
      2'b01:   base = 3'd2;
      default: base = 3'd4;
    endcase
    return base - {2'b00, divSel};
  endfunction

endpackage

// File: rtl/sar_prescaler.sv
module sar_prescaler
  import sar_pkg::*;
#(
  parameter int CNT_W = MAX_SHIFT
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       restart,
  input  logic       run,
  input  logic       divSel,
  input  logic [1:0] clkSel,
  output logic       tick
);

  localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};

  logic [2:0]       shiftQ;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;

  assign limit = ALL_ONES >> (3'(CNT_W) - shiftQ);
  assign tick  = run && (cnt == limit);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftQ <= 3'd0;
      cnt    <= '0;
    end else if (restart) begin
      shiftQ <= divShift(divSel, clkSel);
      cnt    <= '0;
    end else if (run) begin
      cnt <= (cnt == limit) ? '0 : cnt + 1'b1;
    end
  end

endmodule

// File: rtl/sar_ctrl.sv
module sar_ctrl
  import sar_pkg::*;
#(
  parameter int SAMPLE_TICKS = 12,
  parameter int BIT_TICKS    = 18,
  parameter int LATCH_TICKS  = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       rdStrobe,
  input  logic       tick,
  output logic       busy,
  output logic       sampleEn,
  output logic       donePulse,
  output logic       irqFlag,
  output seqStrobe_t strobe
);

  localparam int MAXT_A = (SAMPLE_TICKS > BIT_TICKS) ? SAMPLE_TICKS : BIT_TICKS;
  localparam int MAXT   = (MAXT_A > LATCH_TICKS) ? MAXT_A : LATCH_TICKS;
  localparam int SUB_W  = (MAXT > 2) ? $clog2(MAXT) : 1;
  localparam logic [SUB_W-1:0] SAMPLE_LAST = SUB_W'(SAMPLE_TICKS - 1);
  localparam logic [SUB_W-1:0] BIT_LAST    = SUB_W'(BIT_TICKS - 1);
  localparam logic [SUB_W-1:0] LATCH_LAST  = SUB_W'(LATCH_TICKS - 1);
  localparam logic [IDX_W-1:0] TOP_BIT     = IDX_W'(RES_W - 1);

  seqState_t        state;
  logic [SUB_W-1:0] subCnt;
  logic [IDX_W-1:0] bitIdx;
  logic             doneQ;
  logic             irqQ;
  logic             accept;
  logic             decideNow;
  logic             commitNow;

  assign accept    = startReq && (state == ST_IDLE);
  assign decideNow = (state == ST_DECIDE) && tick && (subCnt == BIT_LAST);
  assign commitNow = (state == ST_LATCH) && tick && (subCnt == LATCH_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      subCnt <= '0;
      bitIdx <= '0;
      doneQ  <= 1'b0;
      irqQ   <= 1'b0;
    end else begin
      doneQ <= commitNow;
      if (commitNow)     irqQ <= 1'b1;
      else if (rdStrobe) irqQ <= 1'b0;

      case (state)
        ST_IDLE: begin
          if (accept) begin
            state  <= ST_SAMPLE;
            subCnt <= '0;
          end
        end
        ST_SAMPLE: begin
          if (tick) begin
            if (subCnt == SAMPLE_LAST) begin
              state  <= ST_DECIDE;
              subCnt <= '0;
              bitIdx <= TOP_BIT;
            end else begin
              subCnt <= subCnt + 1'b1;
            end
          end
        end
        ST_DECIDE: begin
          if (tick) begin
            if (subCnt == BIT_LAST) begin
              subCnt <= '0;
              if (bitIdx == '0) state  <= ST_LATCH;
              else              bitIdx <= bitIdx - 1'b1;
            end else begin
              subCnt <= subCnt + 1'b1;
            end
          end
        end
        default: begin
          if (tick) begin
            if (subCnt == LATCH_LAST) begin
              state  <= ST_IDLE;
              subCnt <= '0;
            end else begin
              subCnt <= subCnt + 1'b1;
            end
          end
        end
      endcase
    end
  end

  assign busy      = (state != ST_IDLE);
  assign sampleEn  = (state == ST_SAMPLE);
  assign donePulse = doneQ;
  assign irqFlag   = irqQ;

  always_comb begin
    strobe.load    = accept;
    strobe.decide  = decideNow;
    strobe.commit  = commitNow;
    strobe.trialOn = (state == ST_DECIDE);
    strobe.bitIdx  = bitIdx;
  end

endmodule

// File: rtl/sar_datapath.sv
module sar_datapath
  import sar_pkg::*;
#(
  parameter int CH_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strobe,
  input  logic [CH_W-1:0]  chanSel,
  input  logic             cmpIn,
  output logic [CH_W-1:0]  muxSel,
  output logic [RES_W-1:0] trialCode,
  output logic [RES_W-1:0] result
);

  logic [RES_W-1:0] acc;
  logic [RES_W-1:0] resultQ;
  logic [CH_W-1:0]  chanQ;
  logic [RES_W-1:0] trialBit;

  assign trialBit  = strobe.trialOn ? (RES_W'(1) << strobe.bitIdx) : '0;
  assign trialCode = acc | trialBit;
  assign muxSel    = chanQ;
  assign result    = resultQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc     <= '0;
      resultQ <= '0;
      chanQ   <= '0;
    end else begin
      if (strobe.load) begin
        acc   <= '0;
        chanQ <= chanSel;
      end else if (strobe.decide && cmpIn) begin
        acc[strobe.bitIdx] <= 1'b1;
      end
      if (strobe.commit) resultQ <= acc;
    end
  end

endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq
  import sar_pkg::*;
#(
  parameter int CH_W         = 3,
  parameter int SAMPLE_TICKS = 12,
  parameter int BIT_TICKS    = 18,
  parameter int LATCH_TICKS  = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic [CH_W-1:0]  chanSel,
  input  logic             divSel,
  input  logic [1:0]       clkSel,
  input  logic             rdStrobe,
  input  logic             cmpIn,
  output logic [CH_W-1:0]  muxSel,
  output logic             sampleEn,
  output logic [RES_W-1:0] trialCode,
  output logic             busy,
  output logic             donePulse,
  output logic             irqFlag,
  output logic [RES_W-1:0] result
);

  seqStrobe_t strobe;
  logic       tick;

  sar_prescaler #(.CNT_W(MAX_SHIFT)) u_presc (
    .clk     (clk),
    .rstN    (rstN),
    .restart (strobe.load),
    .run     (busy),
    .divSel  (divSel),
    .clkSel  (clkSel),
    .tick    (tick)
  );

  sar_ctrl #(
    .SAMPLE_TICKS (SAMPLE_TICKS),
    .BIT_TICKS    (BIT_TICKS),
    .LATCH_TICKS  (LATCH_TICKS)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startReq  (startReq),
    .rdStrobe  (rdStrobe),
    .tick      (tick),
    .busy      (busy),
    .sampleEn  (sampleEn),
    .donePulse (donePulse),
    .irqFlag   (irqFlag),
    .strobe    (strobe)
  );

  sar_datapath #(.CH_W(CH_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .chanSel   (chanSel),
    .cmpIn     (cmpIn),
    .muxSel    (muxSel),
    .trialCode (trialCode),
    .result    (result)
  );

endmodule

// File: rtl/sar_conv_seq_chk.sv
module sar_conv_seq_chk #(
  parameter int CH_W = 3
) (
  input logic            clk,
  input logic            rstN,
  input logic            startReq,
  input logic            busy,
  input logic            sampleEn,
  input logic            donePulse,
  input logic            irqFlag,
  input logic [CH_W-1:0] muxSel,
  input logic [7:0]      result
);

  a_r1_start_sets_busy: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(busy) && $past(startReq)) |-> busy);

  a_r7_mux_held: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(muxSel));

  a_r3_busy_ends_with_done: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> donePulse);

  a_r4_sample_inside_busy: assert property (@(posedge clk) disable iff (!rstN)
    sampleEn |-> busy);

  a_r8_result_only_at_done: assert property (@(posedge clk) disable iff (!rstN)
    !donePulse |-> $stable(result));

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse);

  a_r10_irq_on_done: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |-> irqFlag);

endmodule

bind sar_conv_seq sar_conv_seq_chk #(.CH_W(CH_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .startReq  (startReq),
  .busy      (busy),
  .sampleEn  (sampleEn),
  .donePulse (donePulse),
  .irqFlag   (irqFlag),
  .muxSel    (muxSel),
  .result    (result)
);

// File: tb/sar_conv_seq_bench.sv
`timescale 1ns/1ps
module sar_conv_seq_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startReq = 1'b0;
  logic [2:0] chanSel = 3'd0;
  logic       divSel = 1'b0;
  logic [1:0] clkSel = 2'b00;
  logic       rdStrobe = 1'b0;
  logic       cmpIn;
  logic [2:0] muxSel;
  logic       sampleEn;
  logic [7:0] trialCode;
  logic       busy;
  logic       donePulse;
  logic       irqFlag;
  logic [7:0] result;

  logic [7:0] chanVal [8];

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  // ideal comparator against the selected channel
  assign cmpIn = (chanVal[muxSel] >= trialCode);

  sar_conv_seq u_sar_conv_seq (
    .clk(clk), .rstN(rstN), .startReq(startReq), .chanSel(chanSel),
    .divSel(divSel), .clkSel(clkSel), .rdStrobe(rdStrobe), .cmpIn(cmpIn),
    .muxSel(muxSel), .sampleEn(sampleEn), .trialCode(trialCode), .busy(busy),
    .donePulse(donePulse), .irqFlag(irqFlag), .result(result)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  function automatic int ratioOf(input logic d, input logic [1:0] c);
    if (d) return (c == 2'b00) ? 1 : (c == 2'b01) ? 2 : 8;
    return (c == 2'b00) ? 2 : (c == 2'b01) ? 4 : 16;
  endfunction

  // reference model, advanced on every edge
  bit   mBusy, mDone, mIrq, mFin;
  int   mN, mR;
  logic [2:0] mChan;
  logic [7:0] mVal, mResult;

  always @(posedge clk) begin
    cyc++;
    if (!rstN) begin
      mBusy = 0; mDone = 0; mIrq = 0; mN = 0; mR = 1;
      mChan = 0; mVal = 0; mResult = 0;
    end else begin
      mFin = 0;
      mDone = 0;
      if (mBusy) begin
        mN++;
        if (mN == 160 * mR) begin
          mBusy = 0;
          mResult = mVal;
          mFin = 1;
        end
      end else if (startReq) begin
        mBusy = 1; mN = 0; mR = ratioOf(divSel, clkSel);
        mChan = chanSel; mVal = chanVal[chanSel];
      end
      if (mFin) begin mDone = 1; mIrq = 1; end
      else if (rdStrobe) mIrq = 0;
    end
  end

  function automatic int expTrial();
    int s, b;
    if (!mBusy) return int'(mResult);
    s = mN / mR;
    if (s < 12) return 0;
    if (s < 156) begin
      b = 7 - (s - 12) / 18;
      return (int'(mVal) & ((255 << (b + 1)) & 255)) | (1 << b);
    end
    return int'(mVal);
  endfunction

  always @(negedge clk) begin
    if (!finished) begin
      check(busy == mBusy, "R3 busy", busy, mBusy);
      check(sampleEn == (mBusy && mN < 12 * mR), "R4 sampleEn", sampleEn, (mBusy && mN < 12 * mR));
      check(int'(trialCode) == expTrial(), "R5/R6 trialCode", trialCode, expTrial());
      check(muxSel == mChan, "R1 muxSel", muxSel, mChan);
      check(result == mResult, "R8 result", result, mResult);
      check(donePulse == mDone, "R9 donePulse", donePulse, mDone);
      check(irqFlag == mIrq, "R10 irqFlag", irqFlag, mIrq);
    end
  end

  task automatic summary();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc > 190000 && !finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  // one conversion; pokeAt >= 0 issues a start with another channel mid-run
  task automatic runConv(input int ch, input logic [7:0] val, input logic d,
                         input logic [1:0] c, input bit scramble, input bit holdRd,
                         input int pokeAt);
    int n;
    int r;
    r = ratioOf(d, c);
    @(negedge clk);
    chanVal[ch] = val;
    chanSel = 3'(ch); divSel = d; clkSel = c; startReq = 1'b1; rdStrobe = holdRd;
    @(negedge clk);
    startReq = 1'b0;
    if (scramble) begin divSel = ~divSel; clkSel = ~clkSel; end
    n = 0;
    while (busy) begin
      if (n == pokeAt) begin startReq = 1'b1; chanSel = 3'(ch ^ 7); end
      else startReq = 1'b0;
      n++;
      @(negedge clk);
    end
    startReq = 1'b0;
    check(n == 160 * r, "R2 R3 conversion length", n, 160 * r);
    check(result == val, "R8 final result", result, val);
    check(donePulse == 1'b1, "R9 done at completion", donePulse, 1);
    check(irqFlag == 1'b1, "R10 flag set at completion", irqFlag, 1);
    if (pokeAt >= 0) check(muxSel == 3'(ch), "R7 mid-run start ignored", muxSel, ch);
    rdStrobe = 1'b1;
    @(negedge clk);
    rdStrobe = 1'b0;
    check(donePulse == 1'b0, "R9 done lasts one cycle", donePulse, 0);
    check(irqFlag == 1'b0, "R10 read clears flag", irqFlag, 0);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) chanVal[i] = 8'(i * 29 + 3);
    repeat (5) @(negedge clk);
    check(busy == 0 && sampleEn == 0 && donePulse == 0 && irqFlag == 0,
          "R11 reset flags", {busy, sampleEn, donePulse, irqFlag}, 0);
    check(trialCode == 0 && result == 0 && muxSel == 0,
          "R11 reset data", {trialCode, result}, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(busy == 0 && irqFlag == 0, "R11 idle after reset", {busy, irqFlag}, 0);

    runConv(3, 8'hA5, 1'b1, 2'b00, 0, 0, -1);
    runConv(7, 8'h00, 1'b0, 2'b01, 0, 0, -1);
    runConv(0, 8'hFF, 1'b0, 2'b10, 0, 0, -1);
    runConv(5, 8'h80, 1'b1, 2'b11, 1, 0, -1);
    runConv(2, 8'h7F, 1'b1, 2'b01, 0, 0, 50);
    runConv(6, 8'h01, 1'b0, 2'b00, 0, 1, -1);
    runConv(1, 8'h5A, 1'b1, 2'b10, 1, 0, 400);

    // R7: start held across completion is taken only once busy is low
    @(negedge clk);
    chanVal[4] = 8'h3C;
    chanSel = 3'd4; divSel = 1'b1; clkSel = 2'b00; startReq = 1'b1;
    @(negedge clk);
    while (busy) @(negedge clk);
    check(busy == 1'b0 && donePulse == 1'b1, "R7 completion with start held", busy, 0);
    @(negedge clk);
    check(busy == 1'b1, "R7 held start accepted after completion", busy, 1);
    startReq = 1'b0;
    while (busy) @(negedge clk);
    check(result == 8'h3C, "R8 second result", result, 8'h3C);
    repeat (4) @(negedge clk);
    summary();
  end

endmodule